// File: doc/BRIEF.md
# CAN Error Status and Interrupt Unit

This unit sits beside a CAN protocol engine and turns its raw error events and error counters into a readable status picture and one level interrupt. The engine supplies single-cycle pulses for the six protocol error kinds. It also supplies the transmit and receive error counts, a sticky bus-off indication, idle and busy levels, and a wake pulse. The unit keeps the error bits, works out the warning levels and the fault-confinement state, and latches interrupt flags.

Software reaches four words through a small register port with a 2-bit address and a combinational read path:

| Address | Word |
|---|---|
| 0 | Configuration |
| 1 | Control (interrupt enables) |
| 2 | Error counters |
| 3 | Status |

Protocol error bits clear when the status word is read, so one read reports each error exactly once. Interrupt flags clear only when software writes 1 to them.

Top module: `can_err_status`

## Requirements
- R1: Status word bit 9 is 1 exactly when tx_cnt >= 96 and bit 8 exactly when rx_cnt >= 96; bit 7 follows idle_in and bit 6 follows txrx_in.
- R2: A pulse on err_evt[k] (bit 5 bit-1 error, 4 bit-0, 3 acknowledge, 2 CRC, 1 form, 0 stuff) sets status bit 10+k from the next cycle, and the bit stays set until cleared.
- R3: A cycle with rd_en high and addr = 3 clears status bits 15:10 at the clock edge; an err_evt pulse in that same cycle is still set afterwards.
- R4: Status bits 5:4 read 2'b10 while bus_off_in is high, else 2'b01 when tx_cnt >= 128 or rx_cnt >= 128, else 2'b00.
- R5: Interrupt flags sit at status bits 17, 16, 2, 1 and 0. Writing to addr 3 with a 1 in a flag position clears that flag; an event that sets the flag in the same cycle wins over the clear.
- R6: The error flag (bit 1) sets on any err_evt pulse. The bus-off flag (bit 2) sets only on a rising edge of bus_off_in. The wake flag (bit 0) sets on wake_evt.
- R7: The transmit-warning flag (bit 17) and the receive-warning flag (bit 16) set on a rising edge of status bit 9 and bit 8 respectively, and only while configuration bit 21 is 1.
- R8: The counter word (addr 2) reads tx_cnt in bits 7:0 and rx_cnt in bits 15:8, with all other bits 0.
- R9: After reset every stored bit is 0. The control word (addr 1) keeps only bits 15, 14, 11 and 10 of a write. The configuration word (addr 0) keeps only bit 21. All other bits of both words read 0.
- R10: irq is high when at least one of these holds: the bus-off flag with control bit 15, the error flag with control bit 14, the transmit-warning flag with control bit 11, or the receive-warning flag with control bit 10. The wake flag never drives irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| err_evt | input | 6 | Protocol error pulses (5 bit-1, 4 bit-0, 3 ack, 2 CRC, 1 form, 0 stuff) |
| tx_cnt | input | 8 | Transmit error count |
| rx_cnt | input | 8 | Receive error count |
| bus_off_in | input | 1 | Sticky bus-off level from the engine |
| idle_in | input | 1 | Bus idle level |
| txrx_in | input | 1 | Node transmitting or receiving |
| wake_evt | input | 1 | Wake-up event pulse |
| rd_en | input | 1 | Read strobe (clears errors when addr = 3) |
| wr_en | input | 1 | Write strobe |
| addr | input | 2 | Word select: 0 config, 1 control, 2 counters, 3 status |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the selected word |
| irq | output | 1 | Level interrupt |

## Verification
The stimulus covers several cases. Single error pulses are followed by repeated reads, which separates the sticky behaviour from clear-on-read. Pulses are placed in the same cycle as a read or a write-1-to-clear, which shows which side has priority. Counter sweeps across 96 and 128, first with the global warning enable on and then off, separate the live warning bits from the edge-set flags. A held bus-off level, cleared while still high, confirms that the bus-off flag is set by an edge and not by the level. A bench model updated every clock is compared against the selected read word and irq on every cycle.

// File: rtl/can_est_pkg.sv
package can_est_pkg;
    localparam int unsigned DW      = 32;
    localparam int unsigned NERR    = 6;
    localparam logic [1:0]  A_CFG   = 2'd0;
    localparam logic [1:0]  A_CTRL  = 2'd1;
    localparam logic [1:0]  A_CNT   = 2'd2;
    localparam logic [1:0]  A_STAT  = 2'd3;
    localparam int unsigned B_WARNEN = 21;
    localparam int unsigned B_TWRN  = 17;
    localparam int unsigned B_RWRN  = 16;
    localparam int unsigned B_PERR  = 10;
    localparam int unsigned B_BOFF  = 2;
    localparam int unsigned B_ERR   = 1;
    localparam int unsigned B_WAKE  = 0;
    localparam int unsigned C_BOFF  = 15;
    localparam int unsigned C_ERR   = 14;
    localparam int unsigned C_TWRN  = 11;
    localparam int unsigned C_RWRN  = 10;

    typedef enum logic [1:0] {
        FC_ACTIVE  = 2'b00,
        FC_PASSIVE = 2'b01,
        FC_BUSOFF  = 2'b10
    } fc_e;

    typedef struct packed {
        logic [NERR-1:0] perr;
        logic            twrn_f;
        logic            rwrn_f;
        logic            boff_f;
        logic            err_f;
        logic            wake_f;
        logic [3:0]      ien;     // {boff, err, twrn, rwrn}
        logic            warn_en;
        logic            txw_prev;
        logic            rxw_prev;
        logic            boff_prev;
    } est_state_t;
endpackage

// File: rtl/can_est_confine.sv
module can_est_confine
    import can_est_pkg::*;
#(
    parameter int unsigned CW       = 8,
    parameter int unsigned WARN_LIM = 96,
    parameter int unsigned PASS_LIM = 128
) (
    input  logic [CW-1:0] tx_cnt,
    input  logic [CW-1:0] rx_cnt,
    input  logic          bus_off_in,
    output logic          tx_warn,
    output logic          rx_warn,
    output fc_e           fault
);
    localparam logic [CW:0] WARN_V = (CW+1)'(WARN_LIM);
    localparam logic [CW:0] PASS_V = (CW+1)'(PASS_LIM);

    always_comb begin
        tx_warn = {1'b0, tx_cnt} >= WARN_V;
        rx_warn = {1'b0, rx_cnt} >= WARN_V;
        if (bus_off_in)
            fault = FC_BUSOFF;
        else if (({1'b0, tx_cnt} >= PASS_V) || ({1'b0, rx_cnt} >= PASS_V))
            fault = FC_PASSIVE;
        else
            fault = FC_ACTIVE;
    end
endmodule

// File: rtl/can_est_irq.sv
module can_est_irq #(
    parameter int unsigned NSRC = 4
) (
    input  logic [NSRC-1:0] flag,
    input  logic [NSRC-1:0] en,
    output logic            irq
);
    logic [NSRC-1:0] gated;
    for (genvar i = 0; i < NSRC; i++) begin : g_gate
        assign gated[i] = flag[i] & en[i];
    end
    assign irq = |gated;
endmodule

// File: rtl/can_err_status.sv
module can_err_status
    import can_est_pkg::*;
#(
    parameter int unsigned CW       = 8,
    parameter int unsigned WARN_LIM = 96,
    parameter int unsigned PASS_LIM = 128
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [5:0]    err_evt,
    input  logic [CW-1:0] tx_cnt,
    input  logic [CW-1:0] rx_cnt,
    input  logic          bus_off_in,
    input  logic          idle_in,
    input  logic          txrx_in,
    input  logic          wake_evt,
    input  logic          rd_en,
    input  logic          wr_en,
    input  logic [1:0]    addr,
    input  logic [31:0]   wdata,
    output logic [31:0]   rdata,
    output logic          irq
);
    est_state_t s_d, s_q;
    logic       tx_warn, rx_warn;
    fc_e        fault;

    can_est_confine #(.CW(CW), .WARN_LIM(WARN_LIM), .PASS_LIM(PASS_LIM)) u_conf (
        .tx_cnt    (tx_cnt),
        .rx_cnt    (rx_cnt),
        .bus_off_in(bus_off_in),
        .tx_warn   (tx_warn),
        .rx_warn   (rx_warn),
        .fault     (fault)
    );

    can_est_irq #(.NSRC(4)) u_irq (
        .flag({s_q.boff_f, s_q.err_f, s_q.twrn_f, s_q.rwrn_f}),
        .en  (s_q.ien),
        .irq (irq)
    );

    logic rd_stat, wr_stat, wr_cfg, wr_ctrl;

    always_comb begin
        rd_stat = rd_en && (addr == A_STAT);
        wr_stat = wr_en && (addr == A_STAT);
        wr_cfg  = wr_en && (addr == A_CFG);
        wr_ctrl = wr_en && (addr == A_CTRL);

        s_d = s_q;
        // protocol errors: read clears old bits, new pulses survive
        if (rd_stat) s_d.perr = '0;
        s_d.perr = s_d.perr | err_evt;

        if (wr_cfg)  s_d.warn_en = wdata[B_WARNEN];
        if (wr_ctrl) s_d.ien = {wdata[C_BOFF], wdata[C_ERR], wdata[C_TWRN], wdata[C_RWRN]};

        // write-one-to-clear first, then sets so events win
        if (wr_stat) begin
            s_d.twrn_f = s_q.twrn_f & ~wdata[B_TWRN];
            s_d.rwrn_f = s_q.rwrn_f & ~wdata[B_RWRN];
            s_d.boff_f = s_q.boff_f & ~wdata[B_BOFF];
            s_d.err_f  = s_q.err_f  & ~wdata[B_ERR];
            s_d.wake_f = s_q.wake_f & ~wdata[B_WAKE];
        end
        s_d.err_f  = s_d.err_f  | (|err_evt);
        s_d.boff_f = s_d.boff_f | (bus_off_in & ~s_q.boff_prev);
        s_d.wake_f = s_d.wake_f | wake_evt;
        s_d.twrn_f = s_d.twrn_f | (s_q.warn_en & tx_warn & ~s_q.txw_prev);
        s_d.rwrn_f = s_d.rwrn_f | (s_q.warn_en & rx_warn & ~s_q.rxw_prev);

        s_d.txw_prev  = tx_warn;
        s_d.rxw_prev  = rx_warn;
        s_d.boff_prev = bus_off_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_CFG:  rdata[B_WARNEN] = s_q.warn_en;
            A_CTRL: begin
                rdata[C_BOFF] = s_q.ien[3];
                rdata[C_ERR]  = s_q.ien[2];
                rdata[C_TWRN] = s_q.ien[1];
                rdata[C_RWRN] = s_q.ien[0];
            end
            A_CNT:  begin
                rdata[CW-1:0]    = tx_cnt;
                rdata[2*CW-1:CW] = rx_cnt;
            end
            default: begin
                rdata[B_TWRN]              = s_q.twrn_f;
                rdata[B_RWRN]              = s_q.rwrn_f;
                rdata[B_PERR+NERR-1:B_PERR] = s_q.perr;
                rdata[9]                   = tx_warn;
                rdata[8]                   = rx_warn;
                rdata[7]                   = idle_in;
                rdata[6]                   = txrx_in;
                rdata[5:4]                 = fault;
                rdata[B_BOFF]              = s_q.boff_f;
                rdata[B_ERR]               = s_q.err_f;
                rdata[B_WAKE]              = s_q.wake_f;
            end
        endcase
    end
endmodule

// File: rtl/can_est_chk.sv
module can_est_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [5:0]  err_evt,
    input logic        rd_en,
    input logic        wr_en,
    input logic [1:0]  addr,
    input logic [31:0] wdata,
    input logic [5:0]  perr,
    input logic [4:0]  flags,   // {twrn, rwrn, boff, err, wake}
    input logic        irq
);
    p_perr_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && addr == 2'd3) |=> ((perr & $past(perr)) == $past(perr)));

    p_read_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 2'd3) |=> (perr == $past(err_evt)));

    p_w1c_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd3 && wdata[1] && err_evt == 6'd0) |=> !flags[1]);

    p_errflag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|err_evt) |=> flags[1]);

    p_irq_needs_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[4:1] == 4'd0) |-> !irq);
endmodule

bind can_err_status can_est_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .err_evt(err_evt),
    .rd_en  (rd_en),
    .wr_en  (wr_en),
    .addr   (addr),
    .wdata  (wdata),
    .perr   (s_q.perr),
    .flags  ({s_q.twrn_f, s_q.rwrn_f, s_q.boff_f, s_q.err_f, s_q.wake_f}),
    .irq    (irq)
);

// File: tb/sim_can_err_status.sv
`timescale 1ns/1ps
module sim_can_err_status;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  err_evt = '0;
    logic [7:0]  tx_cnt = '0, rx_cnt = '0;
    logic        bus_off_in = 1'b0, idle_in = 1'b0, txrx_in = 1'b0, wake_evt = 1'b0;
    logic        rd_en = 1'b0, wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    can_err_status u0 (.*);

    // behavioural reference
    bit [5:0] m_perr;
    bit m_tw, m_rw, m_bo, m_er, m_wk;
    bit m_ie_bo, m_ie_er, m_ie_tw, m_ie_rw, m_wen;
    bit m_ptw, m_prw, m_pbo;

    function automatic bit [31:0] model_rd(input int a);
        bit [31:0] v = 0;
        int fc;
        if (a == 0) v[21] = m_wen;
        else if (a == 1) begin
            v[15] = m_ie_bo; v[14] = m_ie_er; v[11] = m_ie_tw; v[10] = m_ie_rw;
        end else if (a == 2) v = {16'd0, rx_cnt, tx_cnt};
        else begin
            fc = bus_off_in ? 2 : ((int'(tx_cnt) >= 128 || int'(rx_cnt) >= 128) ? 1 : 0);
            v[17] = m_tw; v[16] = m_rw;
            for (int k = 0; k < 6; k++) v[10+k] = m_perr[k];
            v[9] = int'(tx_cnt) >= 96; v[8] = int'(rx_cnt) >= 96;
            v[7] = idle_in; v[6] = txrx_in; v[5:4] = 2'(fc);
            v[2] = m_bo; v[1] = m_er; v[0] = m_wk;
        end
        return v;
    endfunction

    function automatic bit model_irq();
        return (m_bo && m_ie_bo) || (m_er && m_ie_er) || (m_tw && m_ie_tw) || (m_rw && m_ie_rw);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_perr = 0; {m_tw, m_rw, m_bo, m_er, m_wk} = 0;
            {m_ie_bo, m_ie_er, m_ie_tw, m_ie_rw, m_wen} = 0;
            {m_ptw, m_prw, m_pbo} = 0;
        end else begin
            bit tw_now, rw_now, old_wen;
            tw_now = int'(tx_cnt) >= 96;
            rw_now = int'(rx_cnt) >= 96;
            old_wen = m_wen;
            if (rd_en && addr == 3) m_perr = 0;
            m_perr |= err_evt;
            if (wr_en && addr == 3) begin
                if (wdata[17]) m_tw = 0;
                if (wdata[16]) m_rw = 0;
                if (wdata[2])  m_bo = 0;
                if (wdata[1])  m_er = 0;
                if (wdata[0])  m_wk = 0;
            end
            if (err_evt != 0) m_er = 1;
            if (bus_off_in && !m_pbo) m_bo = 1;
            if (wake_evt) m_wk = 1;
            if (old_wen && tw_now && !m_ptw) m_tw = 1;
            if (old_wen && rw_now && !m_prw) m_rw = 1;
            if (wr_en && addr == 0) m_wen = wdata[21];
            if (wr_en && addr == 1) begin
                m_ie_bo = wdata[15]; m_ie_er = wdata[14];
                m_ie_tw = wdata[11]; m_ie_rw = wdata[10];
            end
            m_ptw = tw_now; m_prw = rw_now; m_pbo = bus_off_in;
        end
    end

    // every-cycle comparison
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit [31:0] e;
            e = model_rd(int'(addr));
            n_chk++;
            if (rdata !== e) begin
                n_fail++;
                $display("FAIL %s cycle compare addr %0d: actual %h expected %h",
                         addr == 3 ? "R1" : (addr == 2 ? "R8" : "R9"), addr, rdata, e);
            end
            n_chk++;
            if (irq !== model_irq()) begin
                n_fail++;
                $display("FAIL R10 cycle compare irq: actual %b expected %b", irq, model_irq());
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); @(negedge clk); #1;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        addr = a; rd_en = 1'b1; #1 v = rdata; tick(); rd_en = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1; tick(); wr_en = 1'b0; wdata = '0;
    endtask

    task automatic pulse(input logic [5:0] e);
        err_evt = e; tick(); err_evt = '0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1; n_chk++; n_fail++;
            $display("FAIL watchdog expired: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; #1;
        // R9 reset state
        rd(2'd3, v); chk("R9 reset status", v, 32'h0);
        rd(2'd1, v); chk("R9 reset control", v, 32'h0);
        chk("R10 reset irq", {31'd0, irq}, 32'h0);
        // R9 writable bits
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, v); chk("R9 config bit21 only", v, 32'h0020_0000);
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, v); chk("R9 control enables only", v, 32'h0000_CC00);
        // R1 live levels
        idle_in = 1; txrx_in = 1; #1;
        rd(2'd3, v); chk("R1 idle/txrx", v, 32'h0000_00C0);
        // R2 R6 crc error
        pulse(6'b000100);
        #1 chk("R10 irq on error flag", {31'd0, irq}, 32'h1);
        rd(2'd3, v); chk("R2 crc bit + R6 err flag", v, 32'h0000_10C2);
        rd(2'd3, v); chk("R3 cleared by read", v, 32'h0000_00C2);
        // R3 pulse in same cycle as read
        err_evt = 6'b100000; rd(2'd3, v); err_evt = '0;
        rd(2'd3, v); chk("R3 same-cycle pulse survives", v, 32'h0000_80C2);
        rd(2'd3, v); chk("R3 cleared afterwards", v, 32'h0000_00C2);
        // R5 write one to clear
        wr(2'd3, 32'h2);
        #1 chk("R10 irq drops after clear", {31'd0, irq}, 32'h0);
        rd(2'd3, v); chk("R5 err flag cleared", v, 32'h0000_00C0);
        err_evt = 6'b000001; wr(2'd3, 32'h2); err_evt = '0;
        rd(2'd3, v); chk("R5 set wins over clear", v, 32'h0000_04C2);
        wr(2'd3, 32'h2);
        rd(2'd3, v); chk("R5 clear again", v, 32'h0000_00C0);
        // R7 R1 warnings
        tx_cnt = 8'd96; tick();
        rd(2'd3, v); chk("R7 tx warn flag + R1 bit9", v, 32'h0002_02C0);
        chk("R10 irq on tx warn", {31'd0, irq}, 32'h1);
        rd(2'd2, v); chk("R8 tx count field", v, 32'h0000_0060);
        rx_cnt = 8'd100; tick();
        rd(2'd2, v); chk("R8 both counts", v, 32'h0000_6460);
        rd(2'd3, v); chk("R7 rx warn flag", v, 32'h0003_03C0);
        wr(2'd3, 32'h0003_0000);
        rd(2'd3, v); chk("R5 warn flags cleared", v, 32'h0000_03C0);
        // R7 global enable off
        wr(2'd0, 32'h0);
        rx_cnt = 8'd50; tick(); rx_cnt = 8'd100; tick();
        rd(2'd3, v); chk("R7 no flag with enable off", v, 32'h0000_03C0);
        // R4 fault states
        tx_cnt = 8'd130; tick();
        rd(2'd3, v); chk("R4 passive", v, 32'h0000_03D0);
        tx_cnt = 8'd0; rx_cnt = 8'd0; tick();
        rd(2'd3, v); chk("R4 active", v, 32'h0000_00C0);
        bus_off_in = 1; tick();
        rd(2'd3, v); chk("R4 bus-off + R6 flag", v, 32'h0000_00E4);
        chk("R10 irq on bus-off", {31'd0, irq}, 32'h1);
        wr(2'd3, 32'h4); tick();
        rd(2'd3, v); chk("R6 level does not re-set flag", v, 32'h0000_00E0);
        bus_off_in = 0; tick();
        // R6 R10 wake
        wake_evt = 1; tick(); wake_evt = 0;
        rd(2'd3, v); chk("R6 wake flag", v, 32'h0000_00C1);
        chk("R10 wake not on irq", {31'd0, irq}, 32'h0);
        wr(2'd3, 32'h1);
        // R10 enable masks error flag
        wr(2'd1, 32'h0);
        pulse(6'b010000);
        #1 chk("R10 masked error", {31'd0, irq}, 32'h0);
        rd(2'd3, v); chk("R2 bit-0 error kept", v, 32'h0000_40C2);
        tick();
        done = 1;
        summary();
        $finish;
    end
endmodule